// File: doc/BRIEF.md
# LCD Blink and Bank-Swap Controller

This block turns the frame clock of a segment LCD driver into a slow blink timebase and then into two display controls. A programmable divider, whose ratio is picked by a 2-bit blink rate and a power-saving flag, toggles a blink phase with a 50% duty cycle. During the dark half of each blink period the block either blanks every segment or, when the alternate-bank option is chosen and the multiplex mode allows it, tells the RAM output stage to show the alternate bank instead of the primary one.

A display enable input overrides everything and blanks the panel when it is low. Any change of blink rate, power-saving flag or multiplex mode restarts the divider from zero, so a new setting always begins with a full visible half-period. The display RAM, waveform generation and command decoding are outside this block; they feed its inputs and use its outputs.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: After reset the blink phase is 0 (visible), bank select is 0, and the segment blank output equals the inverse of the display enable.
- R2: With blink rate 0 (off) the blink phase stays 0, bank select stays 0, and the blank output depends only on the display enable.
- R3: With the power-saving flag low, the blink phase toggles every NORM_BASE/2, NORM_BASE and 2*NORM_BASE cycles for rates 1, 2 and 3 (full periods NORM_BASE, 2*NORM_BASE, 4*NORM_BASE).
- R4: With the power-saving flag high, the toggle intervals for rates 1, 2 and 3 become SAVE_BASE/2, SAVE_BASE and 2*SAVE_BASE cycles.
- R5: A change of blink rate, power-saving flag or multiplex mode, sampled at a clock edge, forces the phase to 0 after that edge and restarts the interval count; the first toggle follows one full interval later.
- R6: Changes of the alternate-bank option or the display enable do not restart or disturb the blink phase.
- R7: With alternate-bank blinking deselected and a nonzero rate, the blank output is 1 exactly when the phase is 1 (and the display is enabled), and bank select is 0.
- R8: With alternate-bank blinking selected in multiplex mode 0 (static) or 1 (1:2) and a nonzero rate, bank select equals the phase and blinking does not assert blank.
- R9: With alternate-bank blinking selected in multiplex mode 2 (1:3) or 3 (1:4), bank select stays 0 and the block blanks the whole display during phase 1 instead.
- R10: With display enable low the blank output is 1 whatever the blink state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock that the blink divider counts |
| rst | input | 1 | Synchronous active-high reset |
| blinkMode | input | 2 | Blink rate: 0 off, 1 fast, 2 medium, 3 slow |
| powerSave | input | 1 | Selects the shorter power-saving divide ratios |
| altBankBlink | input | 1 | Blink by swapping to the alternate RAM bank |
| muxMode | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| dispEnable | input | 1 | Display enable; low blanks the panel |
| segBlank | output | 1 | 1 turns all segments off |
| bankSel | output | 1 | 1 selects the alternate RAM bank for output |
| blinkPhase | output | 1 | Current blink phase, 1 is the dark half |

## Verification
The bench steps through every blink rate with and without power saving, so a wrong ratio, a swapped rate pair or an off-by-one interval shows as a toggle in the wrong cycle. Configuration changes made in the middle of a dark half separate a correct synchronous restart from a divider that keeps counting, while flipping the alternate-bank option and the enable mid-period shows they leave the phase alone. The bank-swap option is tried in all four multiplex modes, which tells a legal swap (bank select follows the phase, no blanking) from the fallback to whole-display blanking, and the enable is dropped during both halves to show its override.

// File: rtl/lcd_blink_pkg.sv
package lcd_blink_pkg;

  typedef enum logic [1:0] {
    BLINK_OFF  = 2'd0,
    BLINK_FAST = 2'd1,
    BLINK_MID  = 2'd2,
    BLINK_SLOW = 2'd3
  } blinkRate_e;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_DUAL   = 2'd1,
    MUX_TRIPLE = 2'd2,
    MUX_QUAD   = 2'd3
  } muxMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;  // clear counter and phase this cycle
    logic blinkOn;  // a nonzero blink rate is selected
    logic swapOk;   // bank-swap blinking is requested and legal
  } blinkStrobe_t;

endpackage

// File: rtl/lcd_blink_control.sv
module lcd_blink_control
  import lcd_blink_pkg::*;
#(
  parameter int NORM_BASE = 92160,
  parameter int SAVE_BASE = 15360,
  parameter int CW        = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         blinkMode,
  input  logic               powerSave,
  input  logic               altBankBlink,
  input  logic [1:0]         muxMode,
  output blinkStrobe_t       strobe,
  output logic [CW-1:0]      halfLimit
);

  localparam int NormFast = NORM_BASE / 2 - 1;
  localparam int NormMid  = NORM_BASE - 1;
  localparam int NormSlow = 2 * NORM_BASE - 1;
  localparam int SaveFast = SAVE_BASE / 2 - 1;
  localparam int SaveMid  = SAVE_BASE - 1;
  localparam int SaveSlow = 2 * SAVE_BASE - 1;

  blinkRate_e rateNow;
  muxMode_e   muxNow;
  blinkRate_e ratePrev;
  muxMode_e   muxPrev;
  logic       savePrev;
  logic       cfgChanged;

  assign rateNow = blinkRate_e'(blinkMode);
  assign muxNow  = muxMode_e'(muxMode);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratePrev <= BLINK_OFF;
      muxPrev  <= MUX_STATIC;
      savePrev <= 1'b0;
    end else begin
      ratePrev <= rateNow;
      muxPrev  <= muxNow;
      savePrev <= powerSave;
    end
  end

  assign cfgChanged = (rateNow != ratePrev) || (muxNow != muxPrev) ||
                      (powerSave != savePrev);

  always_comb begin
    strobe.blinkOn = (rateNow != BLINK_OFF);
    strobe.restart = cfgChanged || (rateNow == BLINK_OFF);
    strobe.swapOk  = altBankBlink &&
                     ((muxNow == MUX_STATIC) || (muxNow == MUX_DUAL));
  end

  always_comb begin
    halfLimit = '0;
    unique case (rateNow)
      BLINK_FAST: halfLimit = powerSave ? CW'(SaveFast) : CW'(NormFast);
      BLINK_MID:  halfLimit = powerSave ? CW'(SaveMid)  : CW'(NormMid);
      BLINK_SLOW: halfLimit = powerSave ? CW'(SaveSlow) : CW'(NormSlow);
      default:    halfLimit = '0;
    endcase
  end

endmodule

// File: rtl/lcd_blink_datapath.sv
module lcd_blink_datapath
  import lcd_blink_pkg::*;
#(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  blinkStrobe_t  strobe,
  input  logic [CW-1:0] halfLimit,
  input  logic          dispEnable,
  output logic          segBlank,
  output logic          bankSel,
  output logic          blinkPhase
);

  logic [CW-1:0] divCount;
  logic          phaseDark;

  always_ff @(posedge clk) begin
    if (rst || strobe.restart) begin
      divCount  <= '0;
      phaseDark <= 1'b0;
    end else if (divCount >= halfLimit) begin
      divCount  <= '0;
      phaseDark <= ~phaseDark;
    end else begin
      divCount  <= divCount + 1'b1;
    end
  end

  assign blinkPhase = phaseDark;
  assign bankSel    = strobe.blinkOn && strobe.swapOk && phaseDark;
  assign segBlank   = !dispEnable ||
                      (strobe.blinkOn && !strobe.swapOk && phaseDark);

endmodule

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl
  import lcd_blink_pkg::*;
#(
  parameter int NORM_BASE = 92160,
  parameter int SAVE_BASE = 15360
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] blinkMode,
  input  logic       powerSave,
  input  logic       altBankBlink,
  input  logic [1:0] muxMode,
  input  logic       dispEnable,
  output logic       segBlank,
  output logic       bankSel,
  output logic       blinkPhase
);

  localparam int MaxBase = (NORM_BASE > SAVE_BASE) ? NORM_BASE : SAVE_BASE;
  localparam int CW      = $clog2(2 * MaxBase);

  blinkStrobe_t  strobe;
  logic [CW-1:0] halfLimit;

  lcd_blink_control #(
    .NORM_BASE(NORM_BASE),
    .SAVE_BASE(SAVE_BASE),
    .CW(CW)
  ) u_control (
    .clk(clk),
    .rst(rst),
    .blinkMode(blinkMode),
    .powerSave(powerSave),
    .altBankBlink(altBankBlink),
    .muxMode(muxMode),
    .strobe(strobe),
    .halfLimit(halfLimit)
  );

  lcd_blink_datapath #(
    .CW(CW)
  ) u_datapath (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .halfLimit(halfLimit),
    .dispEnable(dispEnable),
    .segBlank(segBlank),
    .bankSel(bankSel),
    .blinkPhase(blinkPhase)
  );

endmodule

// File: rtl/lcd_blink_checker.sv
module lcd_blink_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] blinkMode,
  input logic       powerSave,
  input logic       altBankBlink,
  input logic [1:0] muxMode,
  input logic       dispEnable,
  input logic       segBlank,
  input logic       bankSel,
  input logic       blinkPhase
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2: blinking off keeps the visible phase
  p_off_visible_r2: assert property (@(posedge clk) disable iff (rst)
    (blinkMode == 2'd0) |=> (blinkPhase == 1'b0));

  // R5: configuration change restarts in the visible phase
  p_restart_visible_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && ((blinkMode != $past(blinkMode)) ||
               (powerSave != $past(powerSave)) ||
               (muxMode != $past(muxMode)))) |=> (blinkPhase == 1'b0));

  // R9: the alternate bank is never shown in 1:3 or 1:4 mode or without the option
  p_bank_legal_r9: assert property (@(posedge clk) disable iff (rst)
    bankSel |-> (altBankBlink && (muxMode < 2'd2) && blinkPhase));

  // R10: display enable low always blanks
  p_enable_blank_r10: assert property (@(posedge clk) disable iff (rst)
    !dispEnable |-> segBlank);

  // R8: a bank swap never also blanks an enabled display
  p_swap_no_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (bankSel && dispEnable) |-> !segBlank);

endmodule

bind lcd_blink_ctrl lcd_blink_checker u_checker (
  .clk(clk),
  .rst(rst),
  .blinkMode(blinkMode),
  .powerSave(powerSave),
  .altBankBlink(altBankBlink),
  .muxMode(muxMode),
  .dispEnable(dispEnable),
  .segBlank(segBlank),
  .bankSel(bankSel),
  .blinkPhase(blinkPhase)
);

// File: tb/lcd_blink_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_blink_ctrl_tb;

  localparam int TB_NORM = 24;
  localparam int TB_SAVE = 8;

  typedef struct {
    logic  blank;
    logic  bank;
    logic  phase;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] blinkMode = 2'd0;
  logic       powerSave = 1'b0;
  logic       altBankBlink = 1'b0;
  logic [1:0] muxMode = 2'd0;
  logic       dispEnable = 1'b1;
  logic       segBlank, bankSel, blinkPhase;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  // reference state built from the requirements
  logic [1:0] mPrevRate = 2'd0;
  logic [1:0] mPrevMux  = 2'd0;
  logic       mPrevSave = 1'b0;
  int         mCount = 0;
  logic       mPhase = 1'b0;

  always #4 clk = ~clk;

  lcd_blink_ctrl #(.NORM_BASE(TB_NORM), .SAVE_BASE(TB_SAVE)) u_dut (
    .clk(clk), .rst(rst), .blinkMode(blinkMode), .powerSave(powerSave),
    .altBankBlink(altBankBlink), .muxMode(muxMode), .dispEnable(dispEnable),
    .segBlank(segBlank), .bankSel(bankSel), .blinkPhase(blinkPhase)
  );

  function automatic int toggleInterval(logic [1:0] r, logic s);
    int base;
    base = s ? TB_SAVE : TB_NORM;
    case (r)
      2'd1:    return base / 2;
      2'd2:    return base;
      2'd3:    return 2 * base;
      default: return 1;
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // driver: apply a setting and predict each following cycle
  task automatic drive(logic [1:0] r, logic s, logic [1:0] m, logic a,
                       logic e, int cycles, string tag);
    expItem_t it;
    logic legal;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i == 0) begin
        blinkMode = r; powerSave = s; muxMode = m;
        altBankBlink = a; dispEnable = e;
      end
      if (r != mPrevRate || s != mPrevSave || m != mPrevMux || r == 2'd0) begin
        mCount = 0; mPhase = 1'b0;
      end else if (mCount == toggleInterval(r, s) - 1) begin
        mCount = 0; mPhase = ~mPhase;
      end else begin
        mCount++;
      end
      mPrevRate = r; mPrevSave = s; mPrevMux = m;
      legal = a && (m < 2'd2);
      it.phase = mPhase;
      it.bank  = (r != 2'd0) && legal && mPhase;
      it.blank = !e || ((r != 2'd0) && !legal && mPhase);
      it.tag   = tag;
      expQ.push_back(it);
    end
  endtask

  // monitor: compare after every clock edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        check(it.tag, "blinkPhase", blinkPhase, it.phase);
        check(it.tag, "bankSel", bankSel, it.bank);
        check(it.tag, "segBlank", segBlank, it.blank);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "blinkPhase", blinkPhase, 1'b0);
    check("R1", "bankSel", bankSel, 1'b0);
    check("R1", "segBlank", segBlank, 1'b0);
    dispEnable = 1'b0;
    #1 check("R1", "segBlank enable low", segBlank, 1'b1);

    drive(2'd0, 0, 2'd0, 0, 1, 20, "R2");
    drive(2'd0, 0, 2'd0, 1, 1, 10, "R2");
    drive(2'd1, 0, 2'd0, 0, 1, 50, "R3_R7");
    drive(2'd2, 0, 2'd0, 0, 1, 80, "R3_R7");
    drive(2'd3, 0, 2'd0, 0, 1, 150, "R3_R7");
    drive(2'd1, 1, 2'd0, 0, 1, 20, "R4");
    drive(2'd2, 1, 2'd0, 0, 1, 30, "R4");
    drive(2'd3, 1, 2'd0, 0, 1, 60, "R4");
    // R5: restarts from the middle of a dark half
    drive(2'd1, 0, 2'd0, 0, 1, 18, "R5");
    drive(2'd1, 0, 2'd1, 0, 1, 30, "R5");
    drive(2'd1, 1, 2'd1, 0, 1, 6, "R5");
    drive(2'd1, 0, 2'd1, 0, 1, 30, "R5");
    // R6 and R8: option and enable flips mid-period, legal swap
    drive(2'd1, 0, 2'd1, 1, 1, 17, "R6_R8");
    drive(2'd1, 0, 2'd1, 1, 0, 9, "R6_R10");
    drive(2'd1, 0, 2'd1, 1, 1, 30, "R6_R8");
    drive(2'd2, 0, 2'd0, 1, 1, 60, "R8");
    // R9: swap requested in 1:3 and 1:4
    drive(2'd2, 0, 2'd2, 1, 1, 60, "R9");
    drive(2'd1, 1, 2'd3, 1, 1, 20, "R9");
    // R10: enable low in both halves
    drive(2'd1, 0, 2'd0, 0, 0, 30, "R10");
    drive(2'd1, 0, 2'd0, 1, 0, 30, "R10");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule